// File: doc/BRIEF.md
# Reprogrammable Microcoded Accumulator ALU

This block is the arithmetic and logic unit of an 8-bit accumulator machine. It combines the accumulator value with the B operand register. A 4-bit operation code does not pick a fixed function. Instead, it indexes a 16-entry writable control store. Each entry holds a control word with these fields:

- gating for the A operand;
- a source for the B operand: B, zero or all-ones;
- an optional inversion of B;
- a carry-in;
- a logic function: add, AND, OR or XOR;
- enables for the accumulator write and for the flag update.

Because the control words can be rewritten at run time, the instruction set can be changed after the chip is built.

Every operation runs through a three-cycle sequence:

1. The control word and the operands are captured.
2. The result and the adder carry are computed.
3. The operation commits. During this cycle the block raises `done`, offers the result with an accumulator write strobe, and at the end of the cycle latches the Zero, Equal and Carry flags. Later conditional branches test these flags.

Instruction fetch, the accumulator itself and the register file lie outside the block.

Top module: `ucode_alu`

## Requirements
- R1: After reset, `busy`, `done` and `acc_wr` are low and all three flags are 0. The control store holds the default operation set.
- R2: A `start` seen while idle begins an operation.
  - The inputs `op_code`, `op_a` and `op_b` are captured at that edge.
  - `busy` is high for exactly three cycles.
  - `done` is high only in the third of those cycles, for one cycle.
- R3: By default, codes 0x0 to 0x5 give these results, each modulo 256:
  - ADD: A+B
  - ADDC: A+B+1
  - SUB: A-B
  - SUBB: A-B-1
  - INC: A+1
  - DEC: A-1
- R4: By default, codes 0x6 to 0xB give these results:
  - AND: A&B
  - OR: A|B
  - XOR: A^B
  - ZERO: 0x00
  - CPL: ~A
  - ONE: 0x01
- R5: When the function is add, the Carry flag is the carry-out of the 9-bit sum of the gated operands plus carry-in.
  - SUB sets Carry when A>=B, meaning no borrow occurred.
  - SUBB sets Carry when A>B.
  - The logic functions clear Carry.
- R6: Zero is set when the committed result is 0x00. Equal is set when the captured A equals the captured B.
- R7: CMP (code 0xE) updates the flags like SUB, but keeps `acc_wr` low.
- R8: By default, the reserved codes 0xC, 0xD and 0xF keep `acc_wr` low and leave all flags unchanged.
- R9: The flags change only at the end of the commit cycle of an operation whose flag-update bit is set. At all other times they hold their value.
- R10: A write with `cs_we` high stores `cs_wdata` into entry `cs_addr` in one cycle. The change affects operations started afterwards.
  - The control word layout is: [8] A gate (1 = zero), [7:6] B source (0 = B, 1 = zero, 2 = all-ones, 3 = zero), [5] invert B, [4] carry-in, [3:2] function (0 add, 1 AND, 2 OR, 3 XOR), [1] accumulator write, [0] flag update.
- R11: A `start` received while `busy` is high is ignored. The running operation completes with its own inputs, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_we | input | 1 | Control-store write enable |
| cs_addr | input | 4 | Control-store entry to write |
| cs_wdata | input | 9 | Control word to write |
| start | input | 1 | Begin an operation (accepted only while idle) |
| op_code | input | 4 | Operation code |
| op_a | input | 8 | Accumulator value |
| op_b | input | 8 | B operand register value |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Commit cycle of an operation |
| acc_wr | output | 1 | Accumulator write strobe (during `done`) |
| result | output | 8 | Result to be written to the accumulator |
| flag_z | output | 1 | Latched Zero flag |
| flag_e | output | 1 | Latched Equal flag |
| flag_c | output | 1 | Latched Carry flag |

## Verification
Directed operand pairs exercise every default code:

- Equal operands separate SUB from SUBB carry behaviour and set Equal.
- 0xFF with INC and 0x00 with DEC show carry wrap and the Zero flag.
- Pairs where B is larger show the borrow case of the subtractions.

A long stretch of random codes and operands is checked against a model that is written per mnemonic. It covers the flag-holding behaviour of CMP and of the reserved codes mixed among committing operations. Reprogramming an entry and observing the new function, then restoring it, shows that the store rather than fixed logic defines the operations. A `start` pulse raised mid-operation checks that the sequencer ignores it.

// File: rtl/ualu_pkg.sv
package ualu_pkg;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_AND = 2'd1,
        FN_OR  = 2'd2,
        FN_XOR = 2'd3
    } fn_e;

    typedef enum logic [1:0] {
        BS_REG  = 2'd0,
        BS_ZERO = 2'd1,
        BS_ONES = 2'd2,
        BS_ZALT = 2'd3
    } bsrc_e;

    typedef struct packed {
        logic  a_zero;
        bsrc_e b_src;
        logic  b_inv;
        logic  c_in;
        fn_e   fn;
        logic  wr_acc;
        logic  wr_flags;
    } ctl_word_t;

    localparam int CW_W = $bits(ctl_word_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EXEC = 2'd2,
        ST_COMMIT = 2'd3
    } seq_e;

    function automatic ctl_word_t mk(logic az, bsrc_e bs, logic bi, logic ci,
                                     fn_e f, logic wa, logic wf);
        ctl_word_t w;
        w.a_zero = az; w.b_src = bs; w.b_inv = bi; w.c_in = ci;
        w.fn = f; w.wr_acc = wa; w.wr_flags = wf;
        return w;
    endfunction

    // Power-up operation set, one control word per code.
    function automatic ctl_word_t default_word(int code);
        case (code)
            0:  return mk(1'b0, BS_REG,  1'b0, 1'b0, FN_ADD, 1'b1, 1'b1); // add
            1:  return mk(1'b0, BS_REG,  1'b0, 1'b1, FN_ADD, 1'b1, 1'b1); // add plus one
            2:  return mk(1'b0, BS_REG,  1'b1, 1'b1, FN_ADD, 1'b1, 1'b1); // subtract
            3:  return mk(1'b0, BS_REG,  1'b1, 1'b0, FN_ADD, 1'b1, 1'b1); // subtract minus one
            4:  return mk(1'b0, BS_ZERO, 1'b0, 1'b1, FN_ADD, 1'b1, 1'b1); // increment
            5:  return mk(1'b0, BS_ONES, 1'b0, 1'b0, FN_ADD, 1'b1, 1'b1); // decrement
            6:  return mk(1'b0, BS_REG,  1'b0, 1'b0, FN_AND, 1'b1, 1'b1);
            7:  return mk(1'b0, BS_REG,  1'b0, 1'b0, FN_OR,  1'b1, 1'b1);
            8:  return mk(1'b0, BS_REG,  1'b0, 1'b0, FN_XOR, 1'b1, 1'b1);
            9:  return mk(1'b1, BS_ZERO, 1'b0, 1'b0, FN_ADD, 1'b1, 1'b1); // clear
            10: return mk(1'b0, BS_ONES, 1'b0, 1'b0, FN_XOR, 1'b1, 1'b1); // complement
            11: return mk(1'b1, BS_ZERO, 1'b0, 1'b1, FN_ADD, 1'b1, 1'b1); // constant one
            14: return mk(1'b0, BS_REG,  1'b1, 1'b1, FN_ADD, 1'b0, 1'b1); // compare
            default: return mk(1'b0, BS_REG, 1'b0, 1'b0, FN_ADD, 1'b0, 1'b0); // reserved
        endcase
    endfunction

endpackage

// File: rtl/ualu_store.sv
module ualu_store
    import ualu_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  ctl_word_t       wr_word,
    input  logic [AW-1:0]   rd_addr,
    output ctl_word_t       rd_word
);
    localparam int DEPTH = 1 << AW;

    ctl_word_t mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        ctl_word_t ent_d;
        always_comb begin
            ent_d = mem_q[i];
            if (wr_en && (wr_addr == AW'(i))) ent_d = wr_word;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= default_word(i);
            else        mem_q[i] <= ent_d;
        end
    end

    assign rd_word = mem_q[rd_addr];

    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_word)));

endmodule

// File: rtl/ualu_datapath.sv
module ualu_datapath
    import ualu_pkg::*;
#(
    parameter int DW = 8
) (
    input  ctl_word_t      cw,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  y,
    output logic           cout
);
    logic [DW-1:0] a_g, b_g;
    logic [DW:0]   sum;

    always_comb begin
        a_g = cw.a_zero ? '0 : a;
        case (cw.b_src)
            BS_REG:  b_g = b;
            BS_ONES: b_g = '1;
            default: b_g = '0;
        endcase
        if (cw.b_inv) b_g = ~b_g;
        sum = {1'b0, a_g} + {1'b0, b_g} + {{DW{1'b0}}, cw.c_in};
        cout = 1'b0;
        case (cw.fn)
            FN_ADD: begin y = sum[DW-1:0]; cout = sum[DW]; end
            FN_AND: y = a_g & b_g;
            FN_OR:  y = a_g | b_g;
            default: y = a_g ^ b_g;
        endcase
    end

endmodule

// File: rtl/ucode_alu.sv
module ucode_alu
    import ualu_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OPW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_we,
    input  logic [OPW-1:0]  cs_addr,
    input  logic [8:0]      cs_wdata,
    input  logic            start,
    input  logic [OPW-1:0]  op_code,
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    output logic            busy,
    output logic            done,
    output logic            acc_wr,
    output logic [DW-1:0]   result,
    output logic            flag_z,
    output logic            flag_e,
    output logic            flag_c
);
    typedef struct packed {
        seq_e           st;
        logic [OPW-1:0] op;
        logic [DW-1:0]  a;
        logic [DW-1:0]  b;
        ctl_word_t      cw;
        logic [DW-1:0]  res;
        logic           cy;
        logic           fz;
        logic           fe;
        logic           fc;
    } regs_t;

    regs_t r_q, r_d;
    ctl_word_t store_word;
    logic [DW-1:0] dp_y;
    logic dp_c;

    ualu_store #(.AW(OPW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cs_we),
        .wr_addr (cs_addr),
        .wr_word (ctl_word_t'(cs_wdata)),
        .rd_addr (r_q.op),
        .rd_word (store_word)
    );

    ualu_datapath #(.DW(DW)) u_dp (
        .cw   (r_q.cw),
        .a    (r_q.a),
        .b    (r_q.b),
        .y    (dp_y),
        .cout (dp_c)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: if (start) begin
                r_d.st = ST_READ;
                r_d.op = op_code;
                r_d.a  = op_a;
                r_d.b  = op_b;
            end
            ST_READ: begin
                r_d.cw = store_word;
                r_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.res = dp_y;
                r_d.cy  = dp_c;
                r_d.st  = ST_COMMIT;
            end
            default: begin
                if (r_q.cw.wr_flags) begin
                    r_d.fz = (r_q.res == '0);
                    r_d.fe = (r_q.a == r_q.b);
                    r_d.fc = r_q.cy;
                end
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, cw: default_word(0), default: '0};
        else        r_q <= r_d;
    end

    assign busy   = (r_q.st != ST_IDLE);
    assign done   = (r_q.st == ST_COMMIT);
    assign acc_wr = done && r_q.cw.wr_acc;
    assign result = r_q.res;
    assign flag_z = r_q.fz;
    assign flag_e = r_q.fe;
    assign flag_c = r_q.fc;

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_to_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ##2 done);
    p_wr_in_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |-> done);
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable({flag_z, flag_e, flag_c}));
    p_equal_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.cw.wr_flags) |=> (flag_e == $past(r_q.a == r_q.b)));
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.cw.wr_flags) |=> (flag_z == ($past(result) == '0)));
    p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(r_q.op));

endmodule

// File: tb/tb_ucode_alu.sv
module tb_ucode_alu;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_we = 1'b0;
    logic [3:0] cs_addr = '0;
    logic [8:0] cs_wdata = '0;
    logic start = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] op_a = '0, op_b = '0;
    logic busy, done, acc_wr, flag_z, flag_e, flag_c;
    logic [7:0] result;

    int n_chk = 0, n_bad = 0;
    logic mz = 1'b0, me = 1'b0, mc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ucode_alu dut (
        .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_addr(cs_addr),
        .cs_wdata(cs_wdata), .start(start), .op_code(op_code), .op_a(op_a),
        .op_b(op_b), .busy(busy), .done(done), .acc_wr(acc_wr),
        .result(result), .flag_z(flag_z), .flag_e(flag_e), .flag_c(flag_c)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference per mnemonic (default set): result, write, flag-update, carry.
    task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         output logic [7:0] r, output logic w, output logic f, output logic c);
        logic [8:0] s;
        w = 1'b1; f = 1'b1; c = 1'b0; r = 8'h00;
        case (op)
            4'h0: begin s = {1'b0,a} + {1'b0,b};        r = s[7:0]; c = s[8]; end
            4'h1: begin s = {1'b0,a} + {1'b0,b} + 9'd1; r = s[7:0]; c = s[8]; end
            4'h2: begin r = a - b;       c = (a >= b); end
            4'h3: begin r = a - b - 8'd1; c = (a > b); end
            4'h4: begin r = a + 8'd1;    c = (a == 8'hFF); end
            4'h5: begin r = a - 8'd1;    c = (a != 8'h00); end
            4'h6: r = a & b;
            4'h7: r = a | b;
            4'h8: r = a ^ b;
            4'h9: r = 8'h00;
            4'hA: r = ~a;
            4'hB: r = 8'h01;
            4'hE: begin r = a - b; c = (a >= b); w = 1'b0; end
            default: begin w = 1'b0; f = 1'b0; end
        endcase
    endtask

    // Issue one operation and check it. mode 0: default model, 1: AND override.
    task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                          input int mode, input string req);
        logic [7:0] er; logic ew, ef, ec;
        model(op, a, b, er, ew, ef, ec);
        if (mode == 1) begin er = a & b; ew = 1'b1; ef = 1'b1; ec = 1'b0; end
        start = 1'b1; op_code = op; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
        check({req, " busy"}, {15'd0, busy}, 16'd1);
        @(negedge clk);
        check({req, " early done R2"}, {15'd0, done}, 16'd0);
        @(negedge clk);
        check({req, " done R2"}, {15'd0, done}, 16'd1);
        if (ew) check({req, " result"}, {8'd0, result}, {8'd0, er});
        check({req, " acc_wr"}, {15'd0, acc_wr}, {15'd0, ew});
        check({req, " flags held before commit R9"}, {13'd0, flag_z, flag_e, flag_c},
              {13'd0, mz, me, mc});
        if (ef) begin mz = (er == 8'h00); me = (a == b); mc = ec; end
        @(negedge clk);
        check({req, " done gone R2"}, {14'd0, done, busy}, 16'd0);
        check({req, " flags"}, {13'd0, flag_z, flag_e, flag_c}, {13'd0, mz, me, mc});
    endtask

    task automatic cs_write(input logic [3:0] adr, input logic [8:0] w);
        cs_we = 1'b1; cs_addr = adr; cs_wdata = w;
        @(negedge clk);
        cs_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy/done/wr", {13'd0, busy, done, acc_wr}, 16'd0);
        check("R1 reset flags", {13'd0, flag_z, flag_e, flag_c}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 arithmetic corners
        run_op(4'h0, 8'hF0, 8'h20, 0, "R3 ADD carry R5");
        run_op(4'h1, 8'h7F, 8'h80, 0, "R3 ADDC wrap R5");
        run_op(4'h2, 8'h33, 8'h33, 0, "R3 SUB equal R6");
        run_op(4'h3, 8'h33, 8'h33, 0, "R3 SUBB equal R5");
        run_op(4'h2, 8'h10, 8'h20, 0, "R3 SUB borrow R5");
        run_op(4'h4, 8'hFF, 8'h00, 0, "R3 INC wrap R6");
        run_op(4'h5, 8'h00, 8'h11, 0, "R3 DEC from zero R5");
        // R4 logic and constants
        run_op(4'h6, 8'hCC, 8'hAA, 0, "R4 AND");
        run_op(4'h7, 8'hC0, 8'h0A, 0, "R4 OR");
        run_op(4'h8, 8'h5A, 8'h5A, 0, "R4 XOR zero R6");
        run_op(4'h9, 8'h77, 8'h12, 0, "R4 ZERO");
        run_op(4'hA, 8'h3C, 8'h00, 0, "R4 CPL");
        run_op(4'hB, 8'h99, 8'h99, 0, "R4 ONE");
        // R7 compare, R8 reserved
        run_op(4'h0, 8'hFF, 8'h01, 0, "R5 setup carry");
        run_op(4'hE, 8'h05, 8'h05, 0, "R7 CMP");
        run_op(4'hC, 8'h00, 8'h00, 0, "R8 reserved C");
        run_op(4'hD, 8'h01, 8'h02, 0, "R8 reserved D");
        run_op(4'hF, 8'h00, 8'hFF, 0, "R8 reserved F");

        // R10 reprogram code 0 as AND: fields az=0 bs=0 bi=0 ci=0 fn=1 wa=1 wf=1
        cs_write(4'h0, 9'b0_00_0_0_01_1_1);
        run_op(4'h0, 8'hF3, 8'h3F, 1, "R10 reprogrammed");
        cs_write(4'h0, 9'b0_00_0_0_00_1_1);
        run_op(4'h0, 8'h01, 8'h02, 0, "R10 restored");

        // R11 start while busy
        start = 1'b1; op_code = 4'h0; op_a = 8'h02; op_b = 8'h03;
        @(negedge clk);
        op_code = 4'h6; op_a = 8'h00; op_b = 8'h00;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R11 done", {15'd0, done}, 16'd1);
        check("R11 result kept", {8'd0, result}, 16'h0005);
        mz = 1'b0; me = 1'b0; mc = 1'b0;
        @(negedge clk);
        check("R11 no extra op", {14'd0, busy, done}, 16'd0);
        @(negedge clk);
        check("R11 still idle", {14'd0, busy, done}, 16'd0);

        // Random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 300; i++) begin
            logic [3:0] o; logic [7:0] x, y;
            o = 4'($urandom_range(0, 15));
            x = 8'($urandom);
            y = ($urandom_range(0, 7) == 0) ? x : 8'($urandom);
            run_op(o, x, y, 0, "R3 R4 R5 R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule